// File: doc/BRIEF.md
# Double-Rate Prefetch Data Path

This block sits between a memory core that moves one wide word per internal cycle and a pin-side data bus that carries half-width beats at twice that rate. The wide word is twice the pin width, so each internal cycle lines up with two pin beats. The model uses a single sampling clock that runs at twice the beat rate. That gives four sampling slots per internal word and two slots per beat, so the phase of the strobe against the data can be shown without a second clock or any analog delay.

On a read, a start pulse and a burst-length code begin a burst. The block asks the core for one wide word every four slots with a pop pulse, and sends the low half as the first beat and the high half as the second. It drives a strobe that changes in the same slot as the data: high during the first beat and low during the second. The read output enable is high only while beats are on the bus. On a write, the strobe comes from outside and changes in the middle of each beat. A rising strobe edge captures the first beat and a falling edge captures the second. Each beat has per-byte mask bits. A masked lane keeps its old contents, and the block presents the assembled word with a per-byte write-enable vector.

Top module: `ddr_prefetch_dp`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `rd_oe`, `dqs_out`, `rd_pop` and `wr_valid` are 0, and `wr_word` and `wr_be` are all zeros.
- R2: A burst is started by `rd_go` sampled high while no burst is active. The code `rd_bl` selects how many wide words are popped: 00 gives 1 word (2 beats), 01 gives 2 words (4 beats), and 10 or 11 give 4 words (8 beats). `rd_pop` is high in the cycle after `rd_go` is sampled, and then again every fourth cycle, once for each word.
- R3: Word k, taken at the edge that closes its pop cycle, appears on `dq_out` as its low half for the next two cycles and then as its high half for two cycles.
- R4: While a burst is driven, `dqs_out` is 1 with the low-half beat and 0 with the high-half beat. It changes at the same edge as `dq_out`.
- R5: `rd_oe` goes to 1 together with the first beat and stays 1 for exactly 4 cycles per word. It is 0 at all other times.
- R6: An `rd_go` pulse that arrives while a burst is active is ignored: no further pops and no further beats follow the burst.
- R7: A write word is assembled from two strobe edges. At a sampling edge where `wr_dqs` is seen rising, the low half is captured. Where it is seen falling, the high half is captured, and `wr_valid` pulses for exactly one cycle after that edge.
- R8: When a `wr_dm` bit is 1 at the capture edge, the matching byte lane of `wr_word` keeps its previous value. Bit i of `wr_dm` covers bits [8i+7:8i] of the beat. The low beat maps to lanes 0..W/8-1 of the word and the high beat to the lanes above.
- R9: `wr_be` is the inverse of the captured masks: the low beat's mask inverted in the low bits, the high beat's mask inverted in the high bits.
- R10: Strobe edges on `wr_dqs` are ignored while a read burst is active. No write word is captured and `wr_valid` stays 0.
- R11: The words of one burst are streamed back to back with no idle cycle between the last beat of one word and the first beat of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, two cycles per beat |
| rst | input | 1 | Synchronous active-high reset |
| rd_go | input | 1 | Read burst start pulse |
| rd_bl | input | 2 | Burst length code |
| rd_pop | output | 1 | Request for the next wide read word |
| rd_word | input | 2*W | Wide read word from the core |
| dq_out | output | W | Read beat data |
| dqs_out | output | 1 | Read strobe, edge-aligned with data |
| rd_oe | output | 1 | Output enable for read data and strobe |
| wr_dqs | input | 1 | Write strobe, centred in each beat |
| wr_dq | input | W | Write beat data |
| wr_dm | input | W/8 | Write beat byte masks, 1 = masked |
| wr_word | output | 2*W | Assembled write word |
| wr_be | output | W/4 | Per-byte write enables of the word |
| wr_valid | output | 1 | One-cycle pulse: write word complete |

## Verification
The assertions take the write strobe to be quiet whenever a read burst is active or about to start, apart from the deliberate toggling used to test R10. They also take each write strobe to go high and back low with at least one sample between its edges, so two completions never fall in adjacent cycles. The bench drives each write as four slots: data changes in even slots and the strobe changes in odd slots. It returns the strobe low before any read burst ends, and it starts a new read only after the enable has dropped, except for the one intentional overlapping start pulse.

// File: rtl/ddr_pfx_pkg.sv
package ddr_pfx_pkg;

    // Burst length codes as seen on the read request.
    typedef enum logic [1:0] {
        BLC_TWO   = 2'b00,
        BLC_FOUR  = 2'b01,
        BLC_EIGHT = 2'b10,
        BLC_EIGHT_ALT = 2'b11
    } blen_code_e;

    // Sampling slot inside one wide-word period (two slots per beat).
    typedef enum logic [1:0] {
        SL_LO_A = 2'd0,
        SL_LO_B = 2'd1,
        SL_HI_A = 2'd2,
        SL_HI_B = 2'd3
    } slot_e;

    // Registered pad controls of the read side.
    typedef struct packed {
        logic oe;
        logic strobe;
    } pad_ctl_t;

    localparam int WORD_CNT_W = 3;

    // Number of wide words fetched for one burst code.
    function automatic logic [WORD_CNT_W-1:0] words_for(blen_code_e c);
        case (c)
            BLC_TWO:  return 3'd1;
            BLC_FOUR: return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

    function automatic slot_e next_slot(slot_e s);
        return slot_e'(s + 2'd1);
    endfunction

endpackage

// File: rtl/ddr_rd_serializer.sv
module ddr_rd_serializer
    import ddr_pfx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  blen_code_e     blen,
    output logic           pop,
    input  logic [2*W-1:0] word,
    output logic [W-1:0]   dq,
    output logic           strobe,
    output logic           oe,
    output logic           busy
);

    logic                  active_q;
    slot_e                 slot_q;
    logic [WORD_CNT_W-1:0] left_q;
    logic [W-1:0]          upper_q;
    logic [W-1:0]          dq_q;
    pad_ctl_t              ctl_q;

    assign pop    = active_q && (slot_q == SL_LO_A);
    assign busy   = active_q;
    assign dq     = dq_q;
    assign strobe = ctl_q.strobe;
    assign oe     = ctl_q.oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            slot_q   <= SL_LO_A;
            left_q   <= '0;
            upper_q  <= '0;
            dq_q     <= '0;
            ctl_q    <= '0;
        end else if (!active_q) begin
            ctl_q <= '0;
            if (go) begin
                active_q <= 1'b1;
                slot_q   <= SL_LO_A;
                left_q   <= words_for(blen);
            end
        end else begin
            slot_q <= next_slot(slot_q);
            case (slot_q)
                SL_LO_A: begin
                    dq_q         <= word[W-1:0];
                    upper_q      <= word[2*W-1:W];
                    ctl_q.oe     <= 1'b1;
                    ctl_q.strobe <= 1'b1;
                end
                SL_HI_A: begin
                    dq_q         <= upper_q;
                    ctl_q.strobe <= 1'b0;
                end
                SL_HI_B: begin
                    if (left_q == 3'd1) active_q <= 1'b0;
                    else                left_q   <= left_q - 3'd1;
                end
                default: ;
            endcase
        end
    end

    AST_POP_SPACED: assert property (@(posedge clk) disable iff (rst)
        pop |=> !pop); // R2
    AST_LEFT_LIVE: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (left_q != '0)); // R2
    AST_STROBE_TRACKS_DATA: assert property (@(posedge clk) disable iff (rst)
        (oe && $past(oe) && (dq != $past(dq))) |-> (strobe != $past(strobe))); // R4
    AST_FIRST_BEAT_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> strobe); // R4
    AST_OE_DROPS: assert property (@(posedge clk) disable iff (rst)
        $fell(active_q) |=> !oe); // R5
    AST_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (active_q && slot_q == SL_HI_B && left_q != 3'd1) |=> pop); // R11

endmodule

// File: rtl/ddr_wr_deserializer.sv
module ddr_wr_deserializer
    import ddr_pfx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             block,
    input  logic             dqs,
    input  logic [W-1:0]     dq,
    input  logic [W/8-1:0]   dm,
    output logic [2*W-1:0]   word,
    output logic [W/4-1:0]   be,
    output logic             valid
);

    localparam int LANES = W / 8;

    logic             dqs_q;
    logic             rise;
    logic             fall;
    logic [7:0]       lane_q [2*LANES];
    logic [W/4-1:0]   be_q;
    logic             valid_q;

    assign rise  = dqs && !dqs_q && !block;
    assign fall  = !dqs && dqs_q && !block;
    assign be    = be_q;
    assign valid = valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dqs_q   <= 1'b0;
            be_q    <= '0;
            valid_q <= 1'b0;
            for (int j = 0; j < 2*LANES; j++) lane_q[j] <= '0;
        end else begin
            dqs_q   <= dqs;
            valid_q <= fall;
            if (rise) be_q[LANES-1:0]       <= ~dm;
            if (fall) be_q[2*LANES-1:LANES] <= ~dm;
            for (int i = 0; i < LANES; i++) begin
                if (rise && !dm[i]) lane_q[i]         <= dq[8*i +: 8];
                if (fall && !dm[i]) lane_q[LANES + i] <= dq[8*i +: 8];
            end
        end
    end

    for (genvar g = 0; g < 2*LANES; g++) begin : g_lane_out
        assign word[8*g +: 8] = lane_q[g];
    end

    for (genvar h = 0; h < LANES; h++) begin : g_lane_chk
        AST_MASK_KEEPS_LO: assert property (@(posedge clk) disable iff (rst)
            (rise && dm[h]) |=> $stable(lane_q[h])); // R8
        AST_MASK_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
            (fall && dm[h]) |=> $stable(lane_q[LANES + h])); // R8
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid); // R7
    AST_BLOCKED_IDLE: assert property (@(posedge clk) disable iff (rst)
        (block && $past(block)) |-> !valid); // R10

endmodule

// File: rtl/ddr_prefetch_dp.sv
module ddr_prefetch_dp
    import ddr_pfx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_go,
    input  logic [1:0]       rd_bl,
    output logic             rd_pop,
    input  logic [2*W-1:0]   rd_word,
    output logic [W-1:0]     dq_out,
    output logic             dqs_out,
    output logic             rd_oe,
    input  logic             wr_dqs,
    input  logic [W-1:0]     wr_dq,
    input  logic [W/8-1:0]   wr_dm,
    output logic [2*W-1:0]   wr_word,
    output logic [W/4-1:0]   wr_be,
    output logic             wr_valid
);

    logic rd_busy;

    ddr_rd_serializer #(.W(W)) i_rd (
        .clk    (clk),
        .rst    (rst),
        .go     (rd_go),
        .blen   (blen_code_e'(rd_bl)),
        .pop    (rd_pop),
        .word   (rd_word),
        .dq     (dq_out),
        .strobe (dqs_out),
        .oe     (rd_oe),
        .busy   (rd_busy)
    );

    ddr_wr_deserializer #(.W(W)) i_wr (
        .clk   (clk),
        .rst   (rst),
        .block (rd_busy),
        .dqs   (wr_dqs),
        .dq    (wr_dq),
        .dm    (wr_dm),
        .word  (wr_word),
        .be    (wr_be),
        .valid (wr_valid)
    );

    AST_NO_WRITE_DURING_READ: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> !wr_valid); // R10
    AST_IDLE_STROBE_LOW: assert property (@(posedge clk) disable iff (rst)
        !rd_oe |-> !dqs_out); // R5

endmodule

// File: tb/test_ddr_prefetch_dp.sv
`timescale 1ns/1ps
module test_ddr_prefetch_dp;

    localparam int W = 16;
    localparam int L = W / 8;

    logic           clk = 1'b0;
    logic           rst;
    logic           rd_go;
    logic [1:0]     rd_bl;
    logic           rd_pop;
    logic [2*W-1:0] rd_word;
    logic [W-1:0]   dq_out;
    logic           dqs_out;
    logic           rd_oe;
    logic           wr_dqs;
    logic [W-1:0]   wr_dq;
    logic [L-1:0]   wr_dm;
    logic [2*W-1:0] wr_word;
    logic [2*L-1:0] wr_be;
    logic           wr_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [2*W-1:0] exp_word = '0;

    always #2.5 clk = ~clk;

    ddr_prefetch_dp #(.W(W)) i_ddr_prefetch_dp (
        .clk(clk), .rst(rst), .rd_go(rd_go), .rd_bl(rd_bl), .rd_pop(rd_pop),
        .rd_word(rd_word), .dq_out(dq_out), .dqs_out(dqs_out), .rd_oe(rd_oe),
        .wr_dqs(wr_dqs), .wr_dq(wr_dq), .wr_dm(wr_dm), .wr_word(wr_word),
        .wr_be(wr_be), .wr_valid(wr_valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int words_of(input logic [1:0] c);
        return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
    endfunction

    // Read burst; optionally a second start pulse mid-burst (R6) and
    // strobe toggling on the write side (R10).
    task automatic do_read(input logic [1:0] bl, input bit extra_go, input bit wiggle);
        logic [2*W-1:0] wq [4];
        int n = words_of(bl);
        for (int i = 0; i < 4; i++) wq[i] = {$urandom, $urandom};
        rd_go = 1'b1; rd_bl = bl;
        @(negedge clk);
        rd_go = 1'b0;
        for (int t = 0; t <= 4*n + 1; t++) begin
            check("R2 pop", rd_pop, (t % 4 == 0) && (t < 4*n));
            if (t >= 1 && t <= 4*n) begin
                int k = (t - 1) / 4;
                int p = (t - 1) % 4;
                check("R3 beat data", dq_out, (p < 2) ? wq[k][W-1:0] : wq[k][2*W-1:W]);
                check("R4 strobe", dqs_out, p < 2);
                check("R5 R11 oe", rd_oe, 1'b1);
            end
            if (t == 4*n + 1) check("R5 oe after", rd_oe, 1'b0);
            if (wiggle) check("R10 no capture", wr_valid, 1'b0);
            if (t % 4 == 0 && t < 4*n) rd_word = wq[t/4];
            rd_go = extra_go && (t == 2);
            if (wiggle) begin
                wr_dqs = (t >= 3 && t <= 4*n - 2) ? t[0] : 1'b0;
                wr_dq  = W'($urandom);
                wr_dm  = '0;
            end
            @(negedge clk);
        end
        rd_go = 1'b0; wr_dqs = 1'b0;
        if (extra_go) begin
            for (int i = 0; i < 6; i++) begin
                check("R6 no restart oe", rd_oe, 1'b0);
                check("R6 no restart pop", rd_pop, 1'b0);
                @(negedge clk);
            end
        end
    endtask

    task automatic do_write(input logic [W-1:0] lo, input logic [W-1:0] hi,
                            input logic [L-1:0] mlo, input logic [L-1:0] mhi);
        wr_dq = lo; wr_dm = mlo; wr_dqs = 1'b0;
        @(negedge clk);
        wr_dqs = 1'b1;
        @(negedge clk);
        check("R7 not early", wr_valid, 1'b0);
        wr_dq = hi; wr_dm = mhi;
        @(negedge clk);
        wr_dqs = 1'b0;
        @(negedge clk);
        for (int i = 0; i < L; i++) begin
            if (!mlo[i]) exp_word[8*i +: 8]       = lo[8*i +: 8];
            if (!mhi[i]) exp_word[W + 8*i +: 8]   = hi[8*i +: 8];
        end
        check("R7 valid", wr_valid, 1'b1);
        check("R8 word", wr_word, exp_word);
        check("R9 enables", wr_be, {~mhi, ~mlo});
        wr_dq = '0; wr_dm = '0;
        @(negedge clk);
        check("R7 one pulse", wr_valid, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; rd_go = 1'b0; rd_bl = 2'b00; rd_word = '0;
        wr_dqs = 1'b0; wr_dq = '0; wr_dm = '0;
        repeat (3) @(negedge clk);
        check("R1 oe in reset", rd_oe, 1'b0);
        check("R1 valid in reset", wr_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 oe", rd_oe, 1'b0);
        check("R1 strobe", dqs_out, 1'b0);
        check("R1 pop", rd_pop, 1'b0);
        check("R1 valid", wr_valid, 1'b0);
        check("R1 word", wr_word, '0);
        check("R1 enables", wr_be, '0);

        // Every burst code, directed.
        for (int c = 0; c < 4; c++) begin
            do_read(2'(c), 1'b0, 1'b0);
            repeat (2) @(negedge clk);
        end
        do_read(2'b10, 1'b1, 1'b0);   // R6

        // Writes: directed mask corners, then random.
        do_write(16'hA1B2, 16'hC3D4, 2'b00, 2'b00);
        do_write(16'h1111, 16'h2222, 2'b11, 2'b11);  // R8 all masked
        do_write(16'h5A5A, 16'h6B6B, 2'b01, 2'b10);
        for (int i = 0; i < 20; i++)
            do_write(W'($urandom), W'($urandom), L'($urandom), L'($urandom));

        // Strobe toggled during read must not disturb the write word (R10).
        do_read(2'b01, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        do_write(16'hFFFF, 16'hFFFF, 2'b11, 2'b11);

        // Random reads and writes interleaved.
        for (int i = 0; i < 8; i++) begin
            do_read(2'($urandom), 1'b0, 1'b0);
            repeat (1 + $urandom % 3) @(negedge clk);
            do_write(W'($urandom), W'($urandom), L'($urandom), L'($urandom));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule